// File: doc/BRIEF.md
# SHA-256 Compression Step Sequencer

This block performs one SHA-256 compression over a word-wide memory port. A start request supplies two byte addresses. The first points at the eight-word hash state. The second points at a 64-word message schedule that has already been expanded. The block takes no message block and does no padding or schedule expansion. It reads the state and the schedule words itself, runs the 64 rounds, and writes the updated state back in place over the old one.

The job is a fixed sequence of 80 logical steps in ten groups of eight:

- **Group 0** loads working variables a through h from consecutive state words.
- **Groups 1 to 8** each run eight rounds. Each round fetches its own schedule word.
- **Group 9** re-reads each state word, adds the matching working variable, and stores the sum at the same address.

The memory port has a one-cycle read latency. Every step therefore takes exactly two clock cycles, an issue cycle followed by a consume cycle, so a job lasts 160 cycles. A one-cycle done pulse marks the end of the job.

Top module: `sha256_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_req` and `mem_we` are all low, and they stay low while no job runs.
- R2: A `start` sampled high while idle begins a job. `busy` is then high for exactly 160 cycles. `done` is high only in the one cycle after `busy` falls, which is 161 cycles after the start cycle.
- R3: The first eight accesses of a job are reads of `state_ptr + 4*k`, with k running from 0 to 7 in ascending order. They load a, b, c, d, e, f, g, h in that order.
- R4: The next 64 accesses are reads of `sched_ptr + 4*i`, with i running from 0 to 63, one per round. No write happens before these 72 reads are done.
- R5: Each round applies the SHA-256 round function with the constant K[i], taken from a 64-entry table indexed by the round number. After a job on the standard initial state, memory holds the standard digest.
- R6: The final phase makes, for k from 0 to 7, a read of `state_ptr + 4*k` followed in the next cycle by a write to the same address. The write carries the 32-bit wrapping sum of the read word and variable k. Each job makes exactly 88 accesses and writes nothing outside the state words.
- R7: A `start` while `busy` is high is ignored. The running job keeps its pointers and timing, and no second job follows it.
- R8: Step s (0 to 79) issues its access in cycle 2s+1 after the start cycle. A final-phase write falls in cycle 2s+2. `mem_we` is high only together with `mem_req`. Read data is consumed one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Job request, sampled when idle |
| state_ptr | input | ADDR_W | Byte address of the eight-word state |
| sched_ptr | input | ADDR_W | Byte address of the 64-word schedule |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
Jobs are run with two different message blocks: the empty message and the three-byte "abc" block. Matching digests on both separate a correct round function and constant table from one that only happens to fit a single input. The same block is repeated with the state and schedule placed at other addresses, which shows that pointer arithmetic and address offsets are not hidden behind one fixed layout. One run injects a second start request in the middle of the job, to tell an ignored request apart from one that re-latches pointers or queues a new job. A reset in the middle of a job checks that the port goes quiet and that the next job still gives the right digest.

// File: rtl/sha256_seq_pkg.sv
// Shared constants, types and SHA-256 word functions for the sequencer.
// Assumes 32-bit words; group sizes follow the algorithm and are fixed.
package sha256_seq_pkg;
    localparam int WORD_W     = 32;
    localparam int GRP_LEN    = 8;
    localparam int NUM_GRP    = 10;
    localparam int NUM_STEPS  = GRP_LEN * NUM_GRP;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int POS_W      = $clog2(GRP_LEN);
    localparam int NUM_ROUNDS = 64;
    localparam int RND_W      = $clog2(NUM_ROUNDS);

    typedef logic [WORD_W-1:0] word_t;

    function automatic word_t rotr(word_t x, int n);
        return (x >> n) | (x << (WORD_W - n));
    endfunction

    function automatic word_t sum_a(word_t x);
        return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
    endfunction

    function automatic word_t sum_e(word_t x);
        return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
    endfunction

    function automatic word_t pick(word_t e, word_t f, word_t g);
        return (e & f) ^ (~e & g);
    endfunction

    function automatic word_t vote(word_t a, word_t b, word_t c);
        return (a & b) ^ (a & c) ^ (b & c);
    endfunction
endpackage

// File: rtl/sha256_seq_kconst.sv
// Round-constant table: combinational lookup of K by round number.
// Assumes the index already wraps modulo 64.
module sha256_seq_kconst
    import sha256_seq_pkg::*;
(
    input  logic [RND_W-1:0] idx,
    output word_t            k
);
    localparam word_t KTAB [NUM_ROUNDS] = '{
        32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
        32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
        32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
        32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
        32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
        32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
        32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
        32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
    };

    // Table read for the current round.
    assign k = KTAB[idx];
endmodule

// File: rtl/sha256_seq_ctrl.sv
// Step controller: counts 80 steps of two cycles each (issue, consume),
// keeps the three phase flags and the one-hot position in the group.
// Assumes start is ignored while a job is running.
module sha256_seq_ctrl
    import sha256_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               sub,
    output logic [STEP_W-1:0]  step,
    output logic [GRP_LEN-1:0] pos_oh,
    output logic [POS_W-1:0]   pos_idx,
    output logic [RND_W-1:0]   round_idx,
    output logic               ph_init,
    output logic               ph_comp,
    output logic               ph_fin
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam logic [STEP_W-1:0] LAST_COMP = STEP_W'(NUM_STEPS - GRP_LEN - 1);
    localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(GRP_LEN - 1);

    logic [STEP_W-1:0] rel_step;

    // Position in the group and round number derived from the step count.
    always_comb begin
        pos_idx   = step[POS_W-1:0];
        rel_step  = step - STEP_W'(GRP_LEN);
        round_idx = rel_step[RND_W-1:0];
    end

    // Sequencing of steps, sub-cycles, phases and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            sub     <= 1'b0;
            step    <= '0;
            pos_oh  <= '0;
            ph_init <= 1'b0;
            ph_comp <= 1'b0;
            ph_fin  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sub     <= 1'b0;
                    step    <= '0;
                    pos_oh  <= GRP_LEN'(1);
                    ph_init <= 1'b1;
                    ph_comp <= 1'b0;
                    ph_fin  <= 1'b0;
                end
            end else if (!sub) begin
                sub <= 1'b1;
            end else begin
                sub <= 1'b0;
                if (step == LAST_STEP) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    ph_fin <= 1'b0;
                    pos_oh <= '0;
                    step   <= '0;
                end else begin
                    step   <= step + 1'b1;
                    pos_oh <= {pos_oh[GRP_LEN-2:0], pos_oh[GRP_LEN-1]};
                    if (pos_idx == LAST_POS) begin
                        if (ph_init) begin
                            ph_init <= 1'b0;
                            ph_comp <= 1'b1;
                        end else if (step == LAST_COMP) begin
                            ph_comp <= 1'b0;
                            ph_fin  <= 1'b1;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sha256_seq_round.sv
// Working-variable datapath: eight 32-bit registers a..h (index 0..7)
// that can be loaded one word at a time or advanced by one SHA-256 round.
// Assumes load and round enables are never high together.
module sha256_seq_round
    import sha256_seq_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load_en,
    input  logic [POS_W-1:0]                load_idx,
    input  word_t                           load_word,
    input  logic                            round_en,
    input  word_t                           w_in,
    input  word_t                           k_in,
    output logic [GRP_LEN-1:0][WORD_W-1:0]  vars_o
);
    word_t t1, t2;

    // One round: the two temporaries from the current variables.
    always_comb begin
        t1 = vars_o[7] + sum_e(vars_o[4]) + pick(vars_o[4], vars_o[5], vars_o[6]) + k_in + w_in;
        t2 = sum_a(vars_o[0]) + vote(vars_o[0], vars_o[1], vars_o[2]);
    end

    // Register update: word load during init, shift-and-mix during rounds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vars_o <= '0;
        end else if (load_en) begin
            vars_o[load_idx] <= load_word;
        end else if (round_en) begin
            vars_o[7] <= vars_o[6];
            vars_o[6] <= vars_o[5];
            vars_o[5] <= vars_o[4];
            vars_o[4] <= vars_o[3] + t1;
            vars_o[3] <= vars_o[2];
            vars_o[2] <= vars_o[1];
            vars_o[1] <= vars_o[0];
            vars_o[0] <= t1 + t2;
        end
    end
endmodule

// File: rtl/sha256_seq.sv
// Top: SHA-256 compression sequencer over a word-wide memory port.
// Assumes byte addresses, 32-bit aligned words, and read data valid one
// cycle after the request; each logical step spends two cycles.
module sha256_seq
    import sha256_seq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] state_ptr,
    input  logic [ADDR_W-1:0] sched_ptr,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    logic                           sub;
    logic [STEP_W-1:0]              step;
    logic [GRP_LEN-1:0]             pos_oh;
    logic [POS_W-1:0]               pos_idx;
    logic [RND_W-1:0]               round_idx;
    logic                           ph_init, ph_comp, ph_fin;
    logic [ADDR_W-1:0]              state_q, sched_q;
    logic [GRP_LEN-1:0][WORD_W-1:0] vars;
    word_t                          k_word;

    sha256_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .sub(sub), .step(step), .pos_oh(pos_oh), .pos_idx(pos_idx),
        .round_idx(round_idx), .ph_init(ph_init), .ph_comp(ph_comp), .ph_fin(ph_fin)
    );

    sha256_seq_kconst u_k (.idx(round_idx), .k(k_word));

    sha256_seq_round u_dp (
        .clk(clk), .rst_n(rst_n),
        .load_en(busy && sub && ph_init), .load_idx(pos_idx), .load_word(mem_rdata),
        .round_en(busy && sub && ph_comp), .w_in(mem_rdata), .k_in(k_word),
        .vars_o(vars)
    );

    // Pointer capture on an accepted start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
            sched_q <= '0;
        end else if (start && !busy) begin
            state_q <= state_ptr;
            sched_q <= sched_ptr;
        end
    end

    // Memory port: reads in issue cycles, write-back in final consume cycles.
    always_comb begin
        mem_req   = busy && (!sub || ph_fin);
        mem_we    = busy && sub && ph_fin;
        mem_addr  = ph_comp ? sched_q + ADDR_W'({round_idx, 2'b00})
                            : state_q + ADDR_W'({pos_idx, 2'b00});
        mem_wdata = mem_rdata + vars[pos_idx];
    end
endmodule

// File: rtl/sha256_seq_chk.sv
// Protocol checker for sha256_seq, attached by bind.
// Assumes synchronous active-low reset.
module sha256_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [7:0]        pos_oh,
    input logic              ph_init,
    input logic              ph_comp,
    input logic              ph_fin,
    input logic [ADDR_W-1:0] state_q,
    input logic [ADDR_W-1:0] sched_q
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !mem_we);

    a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_end_marks_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r3_pos_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot(pos_oh));

    a_r4_phase_flags: assert property (@(posedge clk) disable iff (!rst_n)
        busy ? $onehot({ph_init, ph_comp, ph_fin}) : ({ph_init, ph_comp, ph_fin} == 3'b000));

    a_r4_no_write_early: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_init || ph_comp) |-> !mem_we);

    a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(mem_req && !mem_we) && (mem_addr == $past(mem_addr)));

    a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(state_q) && $stable(sched_q));

    a_r8_we_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);
endmodule

bind sha256_seq sha256_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .pos_oh(pos_oh),
    .ph_init(ph_init), .ph_comp(ph_comp), .ph_fin(ph_fin),
    .state_q(state_q), .sched_q(sched_q)
);

// File: tb/sim_sha256_seq.sv
// Bench for sha256_seq: table-driven jobs, then directed reset tests.
module sim_sha256_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] state_ptr = '0, sched_ptr = '0;
    logic        busy, done, mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:255];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_idx = '0;
    logic [31:0] ld_data = '0;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    sha256_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .state_ptr(state_ptr), .sched_ptr(sched_ptr),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model: bench preload port, else one-cycle-latency DUT port.
    always @(posedge clk) begin
        if (ld_en) mem[ld_idx] <= ld_data;
        else if (mem_req) begin
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[9:2]];
        end
    end

    typedef struct packed {
        logic [31:0]  w0;
        logic [31:0]  lenb;
        logic [31:0]  sb;
        logic [31:0]  wb;
        logic [7:0]   ign;
        logic [255:0] dig;
    } vec_t;

    localparam vec_t VECS [3] = '{
        '{32'h80000000, 32'd0,  32'h000, 32'h100, 8'd0,
          256'he3b0c442_98fc1c14_9afbf4c8_996fb924_27ae41e4_649b934c_a495991b_7852b855},
        '{32'h61626380, 32'd24, 32'h3e0, 32'h040, 8'd0,
          256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad},
        '{32'h61626380, 32'd24, 32'h200, 32'h300, 8'd40,
          256'hba7816bf_8f01cfea_414140de_5dae2223_b00361a3_96177a9c_b410ff61_f20015ad}
    };

    localparam logic [255:0] IV =
        256'h6a09e667_bb67ae85_3c6ef372_a54ff53a_510e527f_9b05688c_1f83d9ab_5be0cd19;

    function automatic logic [31:0] rr(logic [31:0] x, int n);
        return (x >> n) | (x << (32 - n));
    endfunction

    task automatic chk(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Preload state (IV) and an expanded schedule for a one-block message.
    task automatic preload(vec_t v, output logic [31:0] w [64]);
        for (int t = 0; t < 64; t++) begin
            if (t == 0) w[t] = v.w0;
            else if (t == 15) w[t] = v.lenb;
            else if (t < 16) w[t] = '0;
            else w[t] = (rr(w[t-2], 17) ^ rr(w[t-2], 19) ^ (w[t-2] >> 10)) + w[t-7]
                      + (rr(w[t-15], 7) ^ rr(w[t-15], 18) ^ (w[t-15] >> 3)) + w[t-16];
        end
        for (int j = 0; j < 72; j++) begin
            @(negedge clk);
            ld_en = 1'b1;
            if (j < 8) begin
                ld_idx = 8'(v.sb[9:2] + 8'(j));
                ld_data = IV[255 - 32*j -: 32];
            end else begin
                ld_idx = 8'(v.wb[9:2] + 8'(j - 8));
                ld_data = w[j-8];
            end
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Run one job, monitoring every cycle, then check the results.
    task automatic run_job(vec_t v, string tag);
        logic [31:0] w [64];
        logic [31:0] ea;
        bit          ew;
        int          ec, m;
        int n = 0, done_at = 0, dwid = 0, busy_bad = 0, quiet_bad = 0;
        int init_bad = 0, sch_bad = 0, fin_bad = 0, tim_bad = 0, rd_before = -1, rd_cnt = 0;
        logic [255:0] got;
        bit sch_keep = 1'b1;
        preload(v, w);
        @(negedge clk);
        state_ptr = v.sb; sched_ptr = v.wb; start = 1'b1;
        for (int c = 1; c <= 170; c++) begin
            @(negedge clk);
            if (c == 1) start = 1'b0;
            if (v.ign != 0 && c == int'(v.ign)) begin
                start = 1'b1; state_ptr = 32'h000; sched_ptr = 32'h100;
            end
            if (v.ign != 0 && c == int'(v.ign) + 1) start = 1'b0;
            if (busy != (c <= 160)) busy_bad++;
            if (done) begin
                if (done_at == 0) done_at = c;
                dwid++;
            end
            if (c > 161 && mem_req) quiet_bad++;
            if (mem_req) begin
                if (n < 72) begin
                    ea = (n < 8) ? v.sb + 32'(4*n) : v.wb + 32'(4*(n-8));
                    ew = 1'b0; ec = 2*n + 1;
                end else begin
                    m = n - 72;
                    ea = v.sb + 32'(4*(m/2)); ew = (m % 2) == 1;
                    ec = 2*(72 + m/2) + 1 + (m % 2);
                end
                if (c != ec) tim_bad++;
                if (mem_addr != ea || mem_we != ew) begin
                    if (n < 8) init_bad++;
                    else if (n < 72) sch_bad++;
                    else fin_bad++;
                end
                if (mem_we && rd_before < 0) rd_before = rd_cnt;
                if (!mem_we) rd_cnt++;
                n++;
            end
        end
        for (int j = 0; j < 8; j++) got[255 - 32*j -: 32] = mem[v.sb[9:2] + 8'(j)];
        for (int j = 0; j < 64; j++) if (mem[v.wb[9:2] + 8'(j)] != w[j]) sch_keep = 1'b0;
        chk(done_at == 161, "R2", {tag, " done cycle"}, 256'(done_at), 256'd161);
        chk(dwid == 1, "R2", {tag, " done width"}, 256'(dwid), 256'd1);
        chk(busy_bad == 0, "R2", {tag, " busy window"}, 256'(busy_bad), 256'd0);
        chk(init_bad == 0, "R3", {tag, " init reads"}, 256'(init_bad), 256'd0);
        chk(sch_bad == 0, "R4", {tag, " schedule reads"}, 256'(sch_bad), 256'd0);
        chk(rd_before == 73, "R4", {tag, " reads before first write"}, 256'(rd_before), 256'd73);
        chk(got == v.dig, "R5", {tag, " digest"}, got, v.dig);
        chk(fin_bad == 0, "R6", {tag, " final read/write pairs"}, 256'(fin_bad), 256'd0);
        chk(n == 88, "R6", {tag, " access count"}, 256'(n), 256'd88);
        chk(sch_keep, "R6", {tag, " schedule untouched"}, 256'(sch_keep), 256'd1);
        chk(tim_bad == 0, "R8", {tag, " access cycles"}, 256'(tim_bad), 256'd0);
        if (v.ign != 0)
            chk(quiet_bad == 0, "R7", {tag, " no job after ignored start"}, 256'(quiet_bad), 256'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, mem_req, mem_we} == 4'b0, "R1", "state after reset",
            256'({busy, done, mem_req, mem_we}), 256'd0);

        for (int i = 0; i < 3; i++) run_job(VECS[i], $sformatf("vec%0d", i));

        // Directed: reset in the middle of a job (R1), then a clean job.
        @(negedge clk);
        state_ptr = 32'h000; sched_ptr = 32'h100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk({busy, done, mem_req, mem_we} == 4'b0, "R1", "mid-job reset",
            256'({busy, done, mem_req, mem_we}), 256'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk({busy, mem_req} == 2'b0, "R1", "idle after reset release",
            256'({busy, mem_req}), 256'd0);
        run_job(VECS[1], "after-reset");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule